// File: doc/BRIEF.md
# Switch Adder with Hex Operand and Decimal Sum Display

This block adds two 8-bit numbers taken from a bank of eighteen switches and drives eight seven-segment digits with no clock at all. The two operands are echoed back in hexadecimal on the four upper digits. Their 9-bit sum is shown in decimal on the four lower digits. Every output is a pure function of the switch bus, so the display tracks the switches as they are flipped.

The sum passes through a combinational binary-to-BCD stage. This stage uses shift-and-add-3 over the nine sum bits and yields four BCD digits. One shared nibble-to-segment decoder serves both the hexadecimal operand digits and the decimal sum digits. A decimal digit never exceeds 9, so only the numeral forms of that decoder are reached on the sum side.

Top module: `switch_sum_display`

## Requirements
- R1: Operand A is sw[16:9]; digit 7 shows its upper nibble and digit 6 its lower nibble, in hexadecimal.
- R2: Operand B is sw[7:0]; digit 5 shows its upper nibble and digit 4 its lower nibble, in hexadecimal.
- R3: The sum A+B is formed on 9 bits so the carry is kept (maximum 510), and it is shown in decimal with leading zeros: digit 3 thousands, digit 2 hundreds, digit 1 tens, digit 0 units.
- R4: Digit 3 always shows the numeral 0, and digit 2 never shows more than 5.
- R5: Switch bits 8 and 17 have no effect on any of the eight digit outputs.
- R6: The block has no clock or storage; every digit output settles to its new value within the same time step as a switch change.
- R7: Each digit output is a 7-bit active-low vector with bit 0 = segment a up to bit 6 = segment g; the codes 0..9 are 7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00, 7'h10, so the numeral 1 lights only segments b and c.
- R8: Nibble values 10..15 are drawn as A, b, C, d, E, F with codes 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E.
- R9: The sum digits 3..0 only ever carry one of the ten numeral codes of R7 and never a letter code of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw | input | 18 | Switch bus: bits 16..9 operand A, bits 7..0 operand B, bits 8 and 17 unused |
| seg_d7 | output | 7 | Operand A upper hex digit, active-low a..g |
| seg_d6 | output | 7 | Operand A lower hex digit, active-low a..g |
| seg_d5 | output | 7 | Operand B upper hex digit, active-low a..g |
| seg_d4 | output | 7 | Operand B lower hex digit, active-low a..g |
| seg_d3 | output | 7 | Sum thousands digit, active-low a..g |
| seg_d2 | output | 7 | Sum hundreds digit, active-low a..g |
| seg_d1 | output | 7 | Sum tens digit, active-low a..g |
| seg_d0 | output | 7 | Sum units digit, active-low a..g |

## Verification
The bound checker watches the properties that hold for any switch setting. Digit 3 must read zero, digit 2 may read at most five, and every sum digit must carry a numeral code and never a letter. An all-zero operand pair must blank to zeros everywhere. These checks cannot show that a digit is the correct one, that the nibbles are wired to the right places, or that the unused switches have no effect. Only the bench can show those. It sweeps every operand pair against sums split with division and modulus, toggles bits 8 and 17 under fixed operands, and samples between clock edges after a switch change.

// File: rtl/sumdisp_pkg.sv
package sumdisp_pkg;
  localparam int SEG_W = 7;
  localparam int NIB_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [NIB_W-1:0] nib_t;
  // active-low, bit 0 = segment a
  localparam seg_t SEG_ZERO = 7'h40;
endpackage

// File: rtl/nib_seg_dec.sv
module nib_seg_dec
  import sumdisp_pkg::*;
(
  input  nib_t val,
  output seg_t seg
);
  seg_t lit; // active-high, bit 0 = a

  always_comb begin
    unique case (val)
      4'h0: lit = 7'b0111111;
      4'h1: lit = 7'b0000110;
      4'h2: lit = 7'b1011011;
      4'h3: lit = 7'b1001111;
      4'h4: lit = 7'b1100110;
      4'h5: lit = 7'b1101101;
      4'h6: lit = 7'b1111101;
      4'h7: lit = 7'b0000111;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1101111;
      4'hA: lit = 7'b1110111;
      4'hB: lit = 7'b1111100;
      4'hC: lit = 7'b0111001;
      4'hD: lit = 7'b1011110;
      4'hE: lit = 7'b1111001;
      default: lit = 7'b1110001;
    endcase
  end

  assign seg = ~lit;
endmodule

// File: rtl/bin_to_bcd.sv
module bin_to_bcd #(
  parameter int IN_W   = 9,
  parameter int DIGITS = 4
) (
  input  logic [IN_W-1:0]       bin,
  output logic [DIGITS*4-1:0]   bcd
);
  localparam int BCD_W = DIGITS * 4;

  logic [BCD_W-1:0] acc;

  // shift-and-add-3, one pass per input bit, MSB first
  always_comb begin
    acc = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[BCD_W-2:0], bin[i]};
    end
  end

  assign bcd = acc;
endmodule

// File: rtl/switch_sum_display.sv
module switch_sum_display
  import sumdisp_pkg::*;
#(
  parameter int OP_W       = 8,
  parameter int DEC_DIGITS = 4
) (
  input  logic [2*OP_W+1:0] sw,
  output logic [6:0]        seg_d7,
  output logic [6:0]        seg_d6,
  output logic [6:0]        seg_d5,
  output logic [6:0]        seg_d4,
  output logic [6:0]        seg_d3,
  output logic [6:0]        seg_d2,
  output logic [6:0]        seg_d1,
  output logic [6:0]        seg_d0
);
  localparam int SUM_W    = OP_W + 1;
  localparam int A_LSB    = OP_W + 1;
  localparam int HEX_DIGS = OP_W / NIB_W;

  logic [OP_W-1:0]         op_a;
  logic [OP_W-1:0]         op_b;
  logic [SUM_W-1:0]        sum;
  logic [DEC_DIGITS*4-1:0] bcd;
  seg_t                    hex_a [HEX_DIGS];
  seg_t                    hex_b [HEX_DIGS];
  seg_t                    dec   [DEC_DIGITS];

  assign op_a = sw[A_LSB +: OP_W];
  assign op_b = sw[0 +: OP_W];
  assign sum  = {1'b0, op_a} + {1'b0, op_b};

  genvar g;
  generate
    for (g = 0; g < HEX_DIGS; g++) begin : g_hex
      nib_seg_dec u_dec_a (.val(op_a[g*NIB_W +: NIB_W]), .seg(hex_a[g]));
      nib_seg_dec u_dec_b (.val(op_b[g*NIB_W +: NIB_W]), .seg(hex_b[g]));
    end
    for (g = 0; g < DEC_DIGITS; g++) begin : g_dec
      nib_seg_dec u_dec_s (.val(bcd[g*4 +: 4]), .seg(dec[g]));
    end
  endgenerate

  bin_to_bcd #(.IN_W(SUM_W), .DIGITS(DEC_DIGITS)) u_bcd (
    .bin (sum),
    .bcd (bcd)
  );

  assign seg_d7 = hex_a[1];
  assign seg_d6 = hex_a[0];
  assign seg_d5 = hex_b[1];
  assign seg_d4 = hex_b[0];
  assign seg_d3 = dec[3];
  assign seg_d2 = dec[2];
  assign seg_d1 = dec[1];
  assign seg_d0 = dec[0];
endmodule

// File: rtl/switch_sum_display_chk.sv
module switch_sum_display_chk (
  input logic [17:0] sw,
  input logic [6:0]  seg_d7,
  input logic [6:0]  seg_d6,
  input logic [6:0]  seg_d5,
  input logic [6:0]  seg_d4,
  input logic [6:0]  seg_d3,
  input logic [6:0]  seg_d2,
  input logic [6:0]  seg_d1,
  input logic [6:0]  seg_d0
);
  function automatic bit is_numeral(input logic [6:0] s, input int max_v);
    logic [6:0] codes [10];
    codes = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00, 7'h10};
    is_numeral = 1'b0;
    for (int i = 0; i <= max_v; i++) if (s == codes[i]) is_numeral = 1'b1;
  endfunction

  always_comb begin
    if (!$isunknown(sw)) begin
      assert_thousands_zero_R4: assert (seg_d3 == 7'h40)
        else $error("digit 3 not zero: %h", seg_d3);
      assert_hundreds_max_R4: assert (is_numeral(seg_d2, 5))
        else $error("digit 2 above five: %h", seg_d2);
      assert_tens_numeral_R9: assert (is_numeral(seg_d1, 9))
        else $error("digit 1 not numeral: %h", seg_d1);
      assert_units_numeral_R9: assert (is_numeral(seg_d0, 9))
        else $error("digit 0 not numeral: %h", seg_d0);
      if (sw[16:9] == 8'd0 && sw[7:0] == 8'd0) begin
        assert_all_zero_R3: assert (seg_d7 == 7'h40 && seg_d6 == 7'h40 && seg_d5 == 7'h40 &&
                                    seg_d4 == 7'h40 && seg_d2 == 7'h40 && seg_d1 == 7'h40 &&
                                    seg_d0 == 7'h40)
          else $error("zero operands not shown as zeros");
      end
    end
  end
endmodule

bind switch_sum_display switch_sum_display_chk u_chk (
  .sw(sw), .seg_d7(seg_d7), .seg_d6(seg_d6), .seg_d5(seg_d5), .seg_d4(seg_d4),
  .seg_d3(seg_d3), .seg_d2(seg_d2), .seg_d1(seg_d1), .seg_d0(seg_d0)
);

// File: tb/switch_sum_display_tb.sv
module switch_sum_display_tb;
  logic        clk;
  logic [17:0] sw;
  logic [6:0]  d7, d6, d5, d4, d3, d2, d1, d0;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;

  switch_sum_display u_dut (
    .sw(sw), .seg_d7(d7), .seg_d6(d6), .seg_d5(d5), .seg_d4(d4),
    .seg_d3(d3), .seg_d2(d2), .seg_d1(d1), .seg_d0(d0)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // R7 / R8 codes, active-low, bit 0 = a
  function automatic logic [6:0] ref_seg(input int v);
    case (v)
      0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
      4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
      8: return 7'h00;  9: return 7'h10;  10: return 7'h08; 11: return 7'h03;
      12: return 7'h46; 13: return 7'h21; 14: return 7'h06; default: return 7'h0E;
    endcase
  endfunction

  function automatic logic [55:0] ref_all(input int a, input int b);
    int s;
    s = a + b;
    return {ref_seg(a / 16), ref_seg(a % 16), ref_seg(b / 16), ref_seg(b % 16),
            ref_seg(s / 1000), ref_seg((s / 100) % 10), ref_seg((s / 10) % 10), ref_seg(s % 10)};
  endfunction

  task automatic check_all(input int a, input int b, input string tag);
    logic [55:0] act, exp;
    act = {d7, d6, d5, d4, d3, d2, d1, d0};
    exp = ref_all(a, b);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", tag, a, b, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit x8, input bit x17);
    @(posedge clk);
    sw = {x17, a[7:0], x8, b[7:0]};
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    sw = '0;
    @(negedge clk);
    // reset state: all switches low -> all zeros
    check_all(0, 0, "R3 R4 reset-state zeros");

    // directed corners
    apply(255, 255, 0, 0); check_all(255, 255, "R3 R4 max sum 510 carry");
    apply(255, 1, 0, 0);   check_all(255, 1, "R3 carry 256");
    apply(1, 0, 0, 0);     check_all(1, 0, "R7 numeral one");
    apply(171, 205, 0, 0); check_all(171, 205, "R8 letters A b C d");
    apply(239, 15, 0, 0);  check_all(239, 15, "R8 letters E F");
    apply(99, 0, 0, 0);    check_all(99, 0, "R9 sum 99");
    apply(60, 40, 0, 0);   check_all(60, 40, "R9 sum 100");

    // R5: ignored switches toggled, outputs must not move
    for (int k = 0; k < 4; k++) begin
      apply(18, 52, k[0], k[1]);
      check_all(18, 52, "R5 ignored bits 8/17");
    end

    // R6: change without any clock edge between drive and sample
    @(negedge clk);
    sw = {1'b0, 8'd200, 1'b0, 8'd77};
    #1;
    check_all(200, 77, "R6 combinational settle");
    sw = {1'b1, 8'd3, 1'b1, 8'd250};
    #1;
    check_all(3, 250, "R6 R5 combinational settle");

    // exhaustive sweep, random unused bits (R1 R2 R3 R5 R9)
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int unsigned r;
        r = $urandom;
        apply(a, b, r[0], r[1]);
        check_all(a, b, "R1 R2 R3 R5 R9 sweep");
      end
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule